// File: doc/BRIEF.md
# Debug Cycle Counter with Breakpoint Request

This block is a 16-bit down counter for on-chip debug logic. One register does three jobs. It can count system clock cycles between two stops of the processor. It can raise a break request when it runs down to zero. It can raise a break request when its value equals the current program counter. A debug host loads the counter through a write port, which has effect only while debug mode is active. The host reads the counter through a port that returns the bitwise complement of the count, so a count running down appears to the host as a value running up.

The break-behaviour selector is sampled into a register every clock, and that register clears to free counting on reset. The counter runs only while its enable is high and the processor is not halted. The break request leaves the block as a pulse one clock long. Halting the processor and carrying debug commands are handled by the surrounding logic.

Top module: `cyc_brk_counter`

## Requirements
- R1: A synchronous active-high reset sets the counter to FFFFh, so `rd_data` reads 0000h. It also sets the registered mode to free count and holds `brk_req` low.
- R2: When `wr_en` and `dbg_active` are both high at a clock edge, the counter takes `wr_data`, and `rd_data` shows `~wr_data` after that edge. A write wins over counting in the same cycle.
- R3: When `wr_en` is high while `dbg_active` is low, the write is ignored and the counter keeps the value that counting alone would give it.
- R4: When `cnt_en` is high, `cpu_halted` is low and no write is accepted, the counter drops by one at each clock edge, so `rd_data` rises by one.
- R5: When `cnt_en` is low or `cpu_halted` is high, and no write is accepted, the counter holds its value.
- R6: `rd_data` is always the bitwise complement of the counter.
- R7: In mode 01 (break on zero), the edge that steps the counter from 1 to 0 also drives `brk_req` high, in the same cycle that `rd_data` first reads FFFFh. The counter then stays at zero and does not wrap, and `brk_req` falls on the next edge.
- R8: In mode 00 (free count), a step from zero wraps the counter to FFFFh, and `brk_req` stays low whatever the count or `pc` is.
- R9: In mode 10 (match), `brk_req` goes high for one cycle, one clock after the first cycle in which the counter equals `pc`. If the equality lasts longer, no further pulse follows.
- R10: Mode 11 behaves as free count: the counter wraps and `brk_req` never rises.
- R11: The `mode` input is registered. A new mode governs the counter from the cycle after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dbg_active | input | 1 | Debug mode is active; host writes are accepted only while this is high |
| cpu_halted | input | 1 | Processor is stopped; counting pauses |
| cnt_en | input | 1 | Counting enable |
| mode | input | 2 | 00 free count, 01 break on zero, 10 break on pc match, 11 free count |
| pc | input | 16 | Current program counter |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Value to load into the counter |
| rd_data | output | 16 | Complement of the counter |
| brk_req | output | 1 | Break request, one clock long |

## Verification
Each test starts from a known loaded value and steps the counter under one mode at a time. This shows that only mode 01 saturates and that modes 00 and 11 wrap. A match test is run once while the counter passes `pc` as it counts, and once while the counter is frozen at `pc`. These two runs tell edge detection apart from level detection. Writes are applied both with debug mode active and with it inactive, and both while the counter is idle and while it is counting. Together these separate precedence from gating. Freezing the counter through `cnt_en` and through `cpu_halted` checks each pause path on its own.

// File: rtl/cyc_brk_pkg.sv
package cyc_brk_pkg;

    typedef enum logic [1:0] {
        BRK_NONE    = 2'b00,
        BRK_ON_ZERO = 2'b01,
        BRK_ON_PC   = 2'b10,
        BRK_RSVD    = 2'b11
    } brk_mode_e;

    typedef struct packed {
        logic load;
        logic step;
    } cnt_ctl_t;

    function automatic logic mode_saturates(brk_mode_e m);
        return m == BRK_ON_ZERO;
    endfunction

    function automatic logic mode_matches_pc(brk_mode_e m);
        return m == BRK_ON_PC;
    endfunction

endpackage

// File: rtl/cbc_ctl.sv
module cbc_ctl
    import cyc_brk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      dbg_active,
    input  logic      cpu_halted,
    input  logic      cnt_en,
    input  logic      wr_en,
    input  logic [1:0] mode,
    output cnt_ctl_t  ctl,
    output brk_mode_e mode_q
);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= BRK_NONE;
        else     mode_q <= brk_mode_e'(mode);
    end

    always_comb begin
        ctl.load = wr_en & dbg_active;
        ctl.step = cnt_en & ~cpu_halted & ~ctl.load;
    end

endmodule

// File: rtl/cbc_counter.sv
module cbc_counter
    import cyc_brk_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_ctl_t     ctl,
    input  brk_mode_e    mode_q,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         last_tick
);

    localparam logic [W-1:0] ZERO     = '0;
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] RST_VAL  = '1;

    logic [W-1:0] cnt_nxt;
    logic         hold_at_zero;

    assign hold_at_zero = mode_saturates(mode_q) && (cnt == ZERO);
    assign last_tick    = ctl.step && (cnt == ONE);

    always_comb begin
        cnt_nxt = cnt;
        if (ctl.load)
            cnt_nxt = load_val;
        else if (ctl.step && !hold_at_zero)
            cnt_nxt = cnt - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= RST_VAL;
        else     cnt <= cnt_nxt;
    end

endmodule

// File: rtl/cbc_brk.sv
module cbc_brk
    import cyc_brk_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  brk_mode_e    mode_q,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] pc,
    input  logic         last_tick,
    output logic         brk_req
);

    logic pc_hit;
    logic pc_hit_q;
    logic zero_hit;

    assign pc_hit   = mode_matches_pc(mode_q) && (cnt == pc);
    assign zero_hit = mode_saturates(mode_q) && last_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_hit_q <= 1'b0;
            brk_req  <= 1'b0;
        end else begin
            pc_hit_q <= pc_hit;
            brk_req  <= zero_hit | (pc_hit & ~pc_hit_q);
        end
    end

endmodule

// File: rtl/cyc_brk_counter.sv
module cyc_brk_counter
    import cyc_brk_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dbg_active,
    input  logic         cpu_halted,
    input  logic         cnt_en,
    input  logic [1:0]   mode,
    input  logic [W-1:0] pc,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic         brk_req
);

    cnt_ctl_t     ctl;
    brk_mode_e    mode_q;
    logic [W-1:0] cnt;
    logic         last_tick;

    cbc_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .dbg_active (dbg_active),
        .cpu_halted (cpu_halted),
        .cnt_en     (cnt_en),
        .wr_en      (wr_en),
        .mode       (mode),
        .ctl        (ctl),
        .mode_q     (mode_q)
    );

    cbc_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mode_q    (mode_q),
        .load_val  (wr_data),
        .cnt       (cnt),
        .last_tick (last_tick)
    );

    cbc_brk #(.W(W)) u_brk (
        .clk       (clk),
        .rst       (rst),
        .mode_q    (mode_q),
        .cnt       (cnt),
        .pc        (pc),
        .last_tick (last_tick),
        .brk_req   (brk_req)
    );

    assign rd_data = ~cnt;

endmodule

// File: rtl/cyc_brk_counter_chk.sv
module cyc_brk_counter_chk
    import cyc_brk_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         dbg_active,
    input logic         cpu_halted,
    input logic         cnt_en,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] pc,
    input logic [W-1:0] rd_data,
    input logic         brk_req,
    input brk_mode_e    mode_q
);

    localparam logic [W-1:0] ALL_ONES = '1;

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dbg_active) |=> (rd_data == ~$past(wr_data)));

    // R3
    write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dbg_active && !(cnt_en && !cpu_halted)) |=> $stable(rd_data));

    // R5
    paused_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && dbg_active) && !(cnt_en && !cpu_halted)) |=> $stable(rd_data));

    // R7
    zero_stick_chk: assert property (@(posedge clk) disable iff (rst)
        ((mode_q == BRK_ON_ZERO) && (rd_data == ALL_ONES) && !(wr_en && dbg_active))
        |=> (rd_data == ALL_ONES));

    // R7
    zero_brk_val_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_req && ($past(mode_q) == BRK_ON_ZERO)) |-> (rd_data == ALL_ONES));

    // R9
    pc_brk_val_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_req && ($past(mode_q) == BRK_ON_PC)) |-> ($past(rd_data) == ~$past(pc)));

    // R10
    no_brk_free_chk: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> (($past(mode_q) == BRK_ON_ZERO) || ($past(mode_q) == BRK_ON_PC)));

endmodule

bind cyc_brk_counter cyc_brk_counter_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dbg_active (dbg_active),
    .cpu_halted (cpu_halted),
    .cnt_en     (cnt_en),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .pc         (pc),
    .rd_data    (rd_data),
    .brk_req    (brk_req),
    .mode_q     (mode_q)
);

// File: tb/cyc_brk_counter_bench.sv
module cyc_brk_counter_bench;

    localparam int CLK_P = 10;
    localparam int WD_CYCLES = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbg_active = 1'b0;
    logic        cpu_halted = 1'b0;
    logic        cnt_en = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [15:0] pc = 16'h0000;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;
    logic        brk_req;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] q_rd[$];
    logic        q_brk[$];
    string       q_req[$];

    always #(CLK_P/2) clk = ~clk;

    cyc_brk_counter u_cyc_brk_counter (
        .clk        (clk),
        .rst        (rst),
        .dbg_active (dbg_active),
        .cpu_halted (cpu_halted),
        .cnt_en     (cnt_en),
        .mode       (mode),
        .pc         (pc),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .brk_req    (brk_req)
    );

    // driver: called at a falling edge, applies inputs, queues the expected result
    task automatic cyc(input logic r, input logic we, input logic dbg, input logic en,
                       input logic halt, input logic [1:0] md, input logic [15:0] wd,
                       input logic [15:0] p, input logic [15:0] exp_rd,
                       input logic exp_brk, input string req);
        rst = r; wr_en = we; dbg_active = dbg; cnt_en = en;
        cpu_halted = halt; mode = md; wr_data = wd; pc = p;
        q_rd.push_back(exp_rd);
        q_brk.push_back(exp_brk);
        q_req.push_back(req);
        @(negedge clk);
    endtask

    // monitor: samples a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (q_rd.size() > 0) begin
            logic [15:0] e_rd;
            logic        e_brk;
            string       e_req;
            e_rd  = q_rd.pop_front();
            e_brk = q_brk.pop_front();
            e_req = q_req.pop_front();
            n_run++;
            if (rd_data !== e_rd || brk_req !== e_brk) begin
                n_fail++;
                $display("FAIL %s: rd_data=%h brk_req=%b expected rd_data=%h brk_req=%b",
                         e_req, rd_data, brk_req, e_rd, e_brk);
            end
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        cyc(1,0,0,0,0,2'b00,16'h0000,16'h0000,16'h0000,0,"R1");
        cyc(1,0,0,0,0,2'b00,16'h0000,16'h0000,16'h0000,0,"R1");
        // R5 paused by enable low, then by halt
        cyc(0,0,0,0,0,2'b00,16'h0000,16'h0000,16'h0000,0,"R5");
        cyc(0,0,0,1,1,2'b00,16'h0000,16'h0000,16'h0000,0,"R5");
        // R3 write outside debug mode while idle
        cyc(0,1,0,0,0,2'b00,16'h1234,16'h0000,16'h0000,0,"R3");
        // R3 write outside debug mode while counting: count only (R4)
        cyc(0,1,0,1,0,2'b00,16'h0000,16'h0000,16'h0001,0,"R3");
        cyc(0,0,0,1,1,2'b00,16'h0000,16'h0000,16'h0001,0,"R5");
        // R2 R6 load in debug mode
        cyc(0,1,1,0,0,2'b00,16'h0005,16'h0000,16'hFFFA,0,"R2");
        cyc(0,1,1,1,0,2'b00,16'h0010,16'h0000,16'hFFEF,0,"R2");
        // R4 counting down, read appears to rise
        cyc(0,0,1,1,0,2'b00,16'h0000,16'h0000,16'hFFF0,0,"R4");
        cyc(0,0,0,1,0,2'b00,16'h0000,16'h0000,16'hFFF1,0,"R4");
        cyc(0,0,0,1,0,2'b00,16'h0000,16'h0000,16'hFFF2,0,"R4");
        cyc(0,0,0,1,0,2'b00,16'h0000,16'h0000,16'hFFF3,0,"R4");
        // R8 free count wraps
        cyc(0,1,1,0,0,2'b00,16'h0001,16'h0000,16'hFFFE,0,"R8");
        cyc(0,0,1,1,0,2'b00,16'h0000,16'h0000,16'hFFFF,0,"R8");
        cyc(0,0,1,1,0,2'b00,16'h0000,16'h0000,16'h0000,0,"R8");
        // R7 R11 break on zero, saturate
        cyc(0,1,1,0,0,2'b01,16'h0003,16'h0000,16'hFFFC,0,"R11");
        cyc(0,0,1,1,0,2'b01,16'h0000,16'h0000,16'hFFFD,0,"R7");
        cyc(0,0,1,1,0,2'b01,16'h0000,16'h0000,16'hFFFE,0,"R7");
        cyc(0,0,1,1,0,2'b01,16'h0000,16'h0000,16'hFFFF,1,"R7");
        cyc(0,0,1,1,0,2'b01,16'h0000,16'h0000,16'hFFFF,0,"R7");
        cyc(0,0,1,1,0,2'b01,16'h0000,16'h0000,16'hFFFF,0,"R7");
        // R10 mode 11 wraps with no break
        cyc(0,1,1,0,0,2'b11,16'h0002,16'h0000,16'hFFFD,0,"R10");
        cyc(0,0,1,1,0,2'b11,16'h0000,16'h0000,16'hFFFE,0,"R10");
        cyc(0,0,1,1,0,2'b11,16'h0000,16'h0000,16'hFFFF,0,"R10");
        cyc(0,0,1,1,0,2'b11,16'h0000,16'h0000,16'h0000,0,"R10");
        // R9 match while counting past pc
        cyc(0,1,1,0,0,2'b10,16'h0008,16'h0005,16'hFFF7,0,"R9");
        cyc(0,0,1,1,0,2'b10,16'h0000,16'h0005,16'hFFF8,0,"R9");
        cyc(0,0,1,1,0,2'b10,16'h0000,16'h0005,16'hFFF9,0,"R9");
        cyc(0,0,1,1,0,2'b10,16'h0000,16'h0005,16'hFFFA,0,"R9");
        cyc(0,0,1,1,0,2'b10,16'h0000,16'h0005,16'hFFFB,1,"R9");
        cyc(0,0,1,1,0,2'b10,16'h0000,16'h0005,16'hFFFC,0,"R9");
        // R9 match held: one pulse only
        cyc(0,1,1,0,0,2'b10,16'h0005,16'h0005,16'hFFFA,0,"R9");
        cyc(0,0,1,0,0,2'b10,16'h0000,16'h0005,16'hFFFA,1,"R9");
        cyc(0,0,1,0,0,2'b10,16'h0000,16'h0005,16'hFFFA,0,"R9");
        cyc(0,0,1,0,0,2'b10,16'h0000,16'h0005,16'hFFFA,0,"R9");
        // R8 free count ignores pc equality
        cyc(0,1,1,0,0,2'b00,16'h0003,16'h0002,16'hFFFC,0,"R8");
        cyc(0,0,1,1,0,2'b00,16'h0000,16'h0002,16'hFFFD,0,"R8");
        cyc(0,0,1,1,0,2'b00,16'h0000,16'h0002,16'hFFFE,0,"R8");
        cyc(0,0,1,1,0,2'b00,16'h0000,16'h0002,16'hFFFF,0,"R8");
        cyc(0,0,1,0,0,2'b00,16'h0000,16'h0002,16'hFFFF,0,"R5");
        while (q_rd.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule